// File: doc/BRIEF.md
# Beat-Frequency Exponential Duty Ramp

This block drives a single output whose duty cycle rises from zero along an exponential curve. It never computes a duty value. Instead, two free-running period timers share one prescaled clock. The first timer has a fixed period and drives the output high each time it wraps. The second timer has a slightly longer period and drives the output low each time it wraps. Because the two periods differ, the second timer's wrap point drifts later within each cycle of the first timer. The high time therefore grows at the beat frequency of the two timers.

After each segment (a fixed number of fixed-timer wraps), the amount by which the second period exceeds the first is halved. This is done by shifting only the low byte of the second period right by one bit. The first period is a multiple of 256, so the high bytes of the two periods always match. The difference starts at 128 and reaches zero after eight segments. The two periods are then equal, the drift stops, and the duty stays constant.

The state machine has three states: `ST_IDLE`, `ST_RAMP` and `ST_HOLD`. It has two named transitions. T_LAUNCH moves `ST_IDLE` to `ST_RAMP` when `start` is seen. T_SETTLE moves `ST_RAMP` to `ST_HOLD` when a segment update shifts the low byte to zero. `ST_HOLD` is left only through `rst`.

Top module: `beat_ramp`

## Requirements
- R1: While `rst` is high and afterwards until a start, `pwm_out` is 0, `seg_idx` is 0, `done` is 0, and the block stays idle.
- R2: A `start` seen while idle launches both timers from count zero in the same cycle. The first rise of `pwm_out` is visible (SET_PERIOD+1)*PRESCALE+1 clock edges after the edge that sampled `start`.
- R3: A fixed-timer wrap makes `pwm_out` 1 on the next edge. A variable-timer wrap makes it 0 on the next edge. When both wrap in the same cycle, the output goes to 1.
- R4: Each timer advances once every PRESCALE clocks and wraps after period+1 advances. Consecutive rises of `pwm_out` early in the ramp are therefore (SET_PERIOD+1)*PRESCALE clocks apart.
- R5: Every SEG_LEN fixed-timer wraps during the ramp, the variable period's low byte shifts right by one bit and its high byte stays equal to the fixed period's high byte. At the same time, `seg_idx` increases by exactly 1.
- R6: A new variable period takes effect only at the variable timer's own wrap. A period already in progress completes at its old length, and the variable period never falls below the fixed period.
- R7: When a segment update makes the low byte zero, `done` rises and stays high until `rst`. `seg_idx` then stays at 8 and segment counting stops.
- R8: `start` has no effect while ramping or holding.
- R9: Once done, the high time of `pwm_out` is the same in every fixed-timer period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch request, honoured only when idle |
| pwm_out | output | 1 | Steered output, set by fixed-timer wraps and cleared by variable-timer wraps |
| seg_idx | output | 4 | Number of segment updates done so far (0 to 8) |
| done | output | 1 | High once the two periods are equal |

## Verification
The hardest case to reach is a cycle in which both timers wrap together. This cycle only occurs when the accumulated phase drift carries the clearing edge across a setting edge. The bench shrinks the fixed period to 256, the prescaler to 2 and the segment length to 2. With these values the total drift of about two fixed periods is swept several times within a few thousand cycles. A cycle-accurate reference model compares every output on every cycle through that sweep. Random start pulses during the ramp and random mid-ramp resets are added to show that launches are ignored when not idle and that a relaunch starts again from zero phase.

// File: rtl/beat_ramp_pkg.sv
package beat_ramp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RAMP = 2'd1,
        ST_HOLD = 2'd2
    } ramp_state_e;

    // Starting excess of the variable period over the fixed one.
    localparam int OFFSET_INIT = 128;
    // Right shifts needed to bring OFFSET_INIT to zero.
    localparam int STEP_COUNT  = $clog2(OFFSET_INIT) + 1;
    localparam int IDX_W       = $clog2(STEP_COUNT + 1);

endpackage

// File: rtl/br_prescaler.sv
module br_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_bypass
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign tick = run;
        end else begin : g_div
            localparam int W = $clog2(DIV);
            localparam logic [W-1:0] LAST = W'(DIV - 1);
            logic [W-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/br_period_timer.sv
module br_period_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] next_period,
    output logic         roll,
    output logic [W-1:0] period
);
    logic [W-1:0] cnt;

    assign roll = run && tick && (cnt == period);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt    <= '0;
            period <= next_period;
        end else if (tick) begin
            if (cnt == period) begin
                cnt    <= '0;
                period <= next_period;   // only at own wrap
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/br_seg_ctrl.sv
module br_seg_ctrl
    import beat_ramp_pkg::*;
#(
    parameter int SEG_LEN = 97
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             set_roll,
    output logic             running,
    output logic             done,
    output logic [7:0]       low_byte,
    output logic [IDX_W-1:0] seg_idx
);
    localparam int SC_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;
    localparam logic [SC_W-1:0] SEG_LAST = SC_W'(SEG_LEN - 1);
    localparam logic [7:0]      LOW_INIT = 8'(OFFSET_INIT);

    ramp_state_e     state_q, state_d;
    logic [SC_W-1:0] seg_cnt;
    logic [7:0]      shifted;
    logic            seg_end;

    assign shifted = low_byte >> 1;
    assign seg_end = set_roll && (seg_cnt == SEG_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state: T_LAUNCH and T_SETTLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RAMP;
            ST_RAMP: if (seg_end && (shifted == 8'd0)) state_d = ST_HOLD;
            ST_HOLD: state_d = ST_HOLD;
            default: state_d = ST_IDLE;
        endcase
    end

    // segment data path
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_cnt  <= '0;
            low_byte <= LOW_INIT;
            seg_idx  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    seg_cnt  <= '0;
                    low_byte <= LOW_INIT;
                end
                ST_RAMP: begin
                    if (seg_end) begin
                        seg_cnt  <= '0;
                        low_byte <= shifted;
                        seg_idx  <= seg_idx + 1'b1;
                    end else if (set_roll) begin
                        seg_cnt <= seg_cnt + 1'b1;
                    end
                end
                ST_HOLD: ;
                default: ;
            endcase
        end
    end

    // outputs from state
    always_comb begin
        running = (state_q != ST_IDLE);
        done    = (state_q == ST_HOLD);
    end
endmodule

// File: rtl/beat_ramp.sv
module beat_ramp
    import beat_ramp_pkg::*;
#(
    parameter int SET_PERIOD = 16'h6100,
    parameter int PRESCALE   = 8,
    parameter int SEG_LEN    = 97
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             pwm_out,
    output logic [IDX_W-1:0] seg_idx,
    output logic             done
);
    localparam logic [15:0] SET_P = 16'(SET_PERIOD);

    logic        tick;
    logic        running;
    logic        set_roll, rst_roll;
    logic [7:0]  low_byte;
    logic [15:0] set_per, rst_per, rst_next;

    assign rst_next = {SET_P[15:8], low_byte};

    br_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk (clk),
        .rst (rst),
        .run (running),
        .tick(tick)
    );

    br_period_timer #(.W(16)) u_set_tmr (
        .clk        (clk),
        .rst        (rst),
        .run        (running),
        .tick       (tick),
        .next_period(SET_P),
        .roll       (set_roll),
        .period     (set_per)
    );

    br_period_timer #(.W(16)) u_rst_tmr (
        .clk        (clk),
        .rst        (rst),
        .run        (running),
        .tick       (tick),
        .next_period(rst_next),
        .roll       (rst_roll),
        .period     (rst_per)
    );

    br_seg_ctrl #(.SEG_LEN(SEG_LEN)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .set_roll(set_roll),
        .running (running),
        .done    (done),
        .low_byte(low_byte),
        .seg_idx (seg_idx)
    );

    // steering: set wins over clear
    always_ff @(posedge clk) begin
        if (rst || !running) begin
            pwm_out <= 1'b0;
        end else if (set_roll) begin
            pwm_out <= 1'b1;
        end else if (rst_roll) begin
            pwm_out <= 1'b0;
        end
    end
endmodule

// File: rtl/beat_ramp_chk.sv
module beat_ramp_chk
    import beat_ramp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             running,
    input logic             set_roll,
    input logic             rst_roll,
    input logic [15:0]      set_per,
    input logic [15:0]      rst_per,
    input logic             pwm_out,
    input logic [IDX_W-1:0] seg_idx,
    input logic             done
);
    AST_IDLE_NO_ROLL: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!set_roll && !rst_roll)); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_roll |=> pwm_out); // R3

    AST_CLEAR_EDGE: assert property (@(posedge clk) disable iff (rst)
        (rst_roll && !set_roll) |=> !pwm_out); // R3

    AST_SEG_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(seg_idx) |-> (seg_idx == $past(seg_idx) + 1'b1)); // R5

    AST_LOAD_AT_ROLL: assert property (@(posedge clk) disable iff (rst)
        (running && !rst_roll) |=> $stable(rst_per)); // R6

    AST_PER_ORDER: assert property (@(posedge clk) disable iff (rst)
        rst_per >= set_per); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> done); // R7

    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(seg_idx)); // R7
endmodule

bind beat_ramp beat_ramp_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .running (running),
    .set_roll(set_roll),
    .rst_roll(rst_roll),
    .set_per (set_per),
    .rst_per (rst_per),
    .pwm_out (pwm_out),
    .seg_idx (seg_idx),
    .done    (done)
);

// File: tb/beat_ramp_bench.sv
module beat_ramp_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SP  = 256;
    localparam int PRE = 2;
    localparam int SL  = 2;
    localparam int FIX_CYC = (SP + 1) * PRE;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       pwm_out;
    logic [3:0] seg_idx;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    beat_ramp #(.SET_PERIOD(SP), .PRESCALE(PRE), .SEG_LEN(SL)) u_beat_ramp (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .pwm_out(pwm_out),
        .seg_idx(seg_idx),
        .done   (done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int next_low(input int low);
        return low >> 1;
    endfunction

    // Reference model built from the requirements
    int m_state = 0, m_pre = 0, m_sc = 0, m_rc = 0;
    int m_rper = SP + 128, m_low = 128, m_segc = 0, m_idx = 0, m_out = 0;

    always @(posedge clk) begin
        int run, tk, sroll, rroll, pend;
        if (rst) begin
            m_state = 0; m_pre = 0; m_sc = 0; m_rc = 0;
            m_low = 128; m_rper = SP + 128; m_segc = 0; m_idx = 0; m_out = 0;
        end else begin
            run   = (m_state != 0);
            tk    = run && (m_pre == PRE - 1);
            sroll = tk && (m_sc == SP);
            rroll = tk && (m_rc == m_rper);
            pend  = (SP & 16'hff00) | m_low;
            if (!run) m_out = 0;
            else if (sroll) m_out = 1;
            else if (rroll) m_out = 0;
            if (!run) begin
                m_sc = 0; m_rc = 0; m_rper = pend; m_pre = 0;
            end else begin
                if (tk) begin
                    m_sc = sroll ? 0 : m_sc + 1;
                    if (rroll) begin m_rc = 0; m_rper = pend; end
                    else m_rc = m_rc + 1;
                end
                m_pre = (m_pre == PRE - 1) ? 0 : m_pre + 1;
            end
            case (m_state)
                0: begin
                    m_low = 128; m_segc = 0;
                    if (start) m_state = 1;
                end
                1: if (sroll) begin
                    if (m_segc == SL - 1) begin
                        m_segc = 0;
                        m_low  = next_low(m_low);
                        m_idx  = m_idx + 1;
                        if (m_low == 0) m_state = 2;
                    end else begin
                        m_segc = m_segc + 1;
                    end
                end
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3 R6 pwm_out vs model", int'(pwm_out), m_out);
            chk("R5 R8 seg_idx vs model", int'(seg_idx), m_idx);
            chk("R7 done vs model", int'(done), (m_state == 2) ? 1 : 0);
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int n, h1, h2;
        void'($urandom(32'd4242));

        // R1: reset state
        repeat (4) @(negedge clk);
        cmp_on = 1'b1;
        chk("R1 pwm_out in reset", int'(pwm_out), 0);
        chk("R1 seg_idx in reset", int'(seg_idx), 0);
        chk("R1 done in reset", int'(done), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk("R1 pwm_out idle", int'(pwm_out), 0);
        chk("R1 done idle", int'(done), 0);

        // R2: first rise after launch
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!pwm_out) begin @(negedge clk); n++; end
        chk("R2 cycles to first rise", n, FIX_CYC + 1);

        // R4: rise-to-rise spacing early in ramp
        n = 0;
        while (pwm_out)  begin @(negedge clk); n++; end
        while (!pwm_out) begin @(negedge clk); n++; end
        chk("R4 rise spacing", n, FIX_CYC);

        // R7: completion
        while (!done) @(negedge clk);
        chk("R7 seg_idx at done", int'(seg_idx), 8);
        repeat (FIX_CYC * 3) @(negedge clk);
        chk("R7 done held", int'(done), 1);
        chk("R7 seg_idx frozen", int'(seg_idx), 8);

        // R9: constant high time once done
        h1 = 0; h2 = 0;
        for (int i = 0; i < FIX_CYC; i++) begin @(negedge clk); h1 += int'(pwm_out); end
        for (int i = 0; i < FIX_CYC; i++) begin @(negedge clk); h2 += int'(pwm_out); end
        chk("R9 high time repeats", h2, h1);

        // R8: start while holding is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (FIX_CYC) @(negedge clk);
        chk("R8 done after stray start", int'(done), 1);
        chk("R8 seg_idx after stray start", int'(seg_idx), 8);

        // Random: noisy start, mid-ramp reset, relaunch
        for (int pass = 0; pass < 2; pass++) begin
            rst = 1'b1;
            repeat (2) @(negedge clk);
            rst = 1'b0;
            repeat ($urandom_range(20, 0)) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            n = $urandom_range(3000, 100);
            for (int i = 0; i < n; i++) begin
                start = (($urandom % 8) == 0);
                @(negedge clk);
            end
            start = 1'b0;
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        start = 1'b1;
        @(negedge clk);
        while (!done) begin
            start = (($urandom % 16) == 0);
            @(negedge clk);
        end
        start = 1'b0;
        repeat (FIX_CYC * 2) @(negedge clk);
        chk("R7 seg_idx after random run", int'(seg_idx), 8);

        summary();
        $finish;
    end
endmodule